// File: doc/BRIEF.md
# MSR Access Exit Decision Unit

This unit decides, for each guest attempt to read or write a model-specific register, whether the access must trap to the hypervisor. A request carries a 32-bit register index, a read/write flag and the control bit that enables permission bitmaps. The unit answers with a single exit/no-exit verdict, marked by a one-cycle valid strobe.

The permissions are held in a 4 KB bitmap in a memory with a synchronous read port. The unit range-checks the index against two windows of 8,192 registers each: a low window starting at 0x00000000 and a high window starting at 0xC0000000. For an index inside a window, it computes the byte address and the bit position, fetches that byte and selects the bit. An index outside both windows, or a cleared enable bit, forces an exit and does not touch the memory.

Every verdict arrives one cycle after its request is accepted, whether or not a lookup took place. Verdicts therefore come back in request order. Only one lookup is outstanding at a time, and the ready output drops while a lookup is pending.

Top module: `msr_exit_unit`

## Requirements
- R1: With the bitmap-enable input at 0, every accepted request yields rsp_exit_o=1 and raises no memory request.
- R2: An index outside 0x00000000..0x00001FFF and outside 0xC0000000..0xC0001FFF yields rsp_exit_o=1 and raises no memory request.
- R3: A read in the low window with index n drives mem_addr_o = n>>3, in the read-low quarter at byte offset 0x000.
- R4: A read in the high window drives mem_addr_o = 0x400 + ((n & 0x1FFF)>>3).
- R5: A write uses the write half: the low window at 0x800 + (n>>3) and the high window at 0xC00 + ((n & 0x1FFF)>>3).
- R6: The selected bit is bit n[2:0] of the fetched byte, counted from the least-significant bit. A 1 gives rsp_exit_o=1 and a 0 gives rsp_exit_o=0.
- R7: rsp_valid_o pulses high for exactly one cycle, in the cycle after each accepted request, and never at any other time.
- R8: After a request that raised a memory request is accepted, req_ready_o is 0 for the next cycle. mem_req_o is raised only on an accepted request.
- R9: After reset, req_ready_o=1, rsp_valid_o=0 and mem_req_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A request is presented |
| req_ready_o | output | 1 | The unit can accept a request |
| req_idx_i | input | 32 | Register index |
| req_write_i | input | 1 | 1 for a write access, 0 for a read access |
| req_bmp_en_i | input | 1 | Bitmap-enable control; at 0 every access exits |
| rsp_valid_o | output | 1 | Verdict strobe |
| rsp_exit_o | output | 1 | 1 means the access traps |
| mem_req_o | output | 1 | Bitmap byte read enable |
| mem_addr_o | output | 12 | Bitmap byte address |
| mem_rdata_i | input | 8 | Bitmap byte, valid one cycle after mem_req_o |

## Verification
The assertions check on every cycle the properties that can be seen at the ports. No lookup is made when the enable bit is clear or the index is out of range, and the verdict in that case is an exit. The quarter base and byte address are checked for each kind of access, and the bit taken from the returned byte is checked against the index's low bits. The assertions also check the one-cycle response timing and the ready drop after a lookup. The bench sweeps every index of all four quarters against a bitmap it fills arithmetically. That sweep shows what the assertions cannot: that the whole address range maps onto distinct bytes, and that every verdict matches the bench's expected bit value.

// File: rtl/msr_exit_pkg.sv
package msr_exit_pkg;
  localparam int unsigned IDX_W     = 32;
  localparam int unsigned WIN_BITS  = 13;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [IDX_W-1:0] HIGH_BASE = 32'hC000_0000;

  // quarter order is {write, high}
  typedef enum logic [1:0] {
    Q_RD_LO = 2'd0,
    Q_RD_HI = 2'd1,
    Q_WR_LO = 2'd2,
    Q_WR_HI = 2'd3
  } quarter_e;
endpackage

// File: rtl/msr_win_decode.sv
module msr_win_decode #(
  parameter int unsigned IDX_W    = 32,
  parameter int unsigned WIN_BITS = 13,
  parameter int unsigned BYTE_W   = 8,
  parameter logic [IDX_W-1:0] HIGH_BASE = 32'hC000_0000,
  localparam int unsigned SEL_W  = $clog2(BYTE_W),
  localparam int unsigned ADDR_W = 2 + WIN_BITS - SEL_W
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              write_i,
  input  logic              bmp_en_i,
  output logic              lookup_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEL_W-1:0]  sel_o
);
  import msr_exit_pkg::*;

  localparam int unsigned TOP_W = IDX_W - WIN_BITS;

  logic     in_low, in_high;
  quarter_e quarter;

  assign in_low  = (idx_i[IDX_W-1:WIN_BITS] == '0);
  assign in_high = (idx_i[IDX_W-1:WIN_BITS] == HIGH_BASE[IDX_W-1:WIN_BITS]);

  always_comb begin
    unique case ({write_i, in_high})
      2'b00:   quarter = Q_RD_LO;
      2'b01:   quarter = Q_RD_HI;
      2'b10:   quarter = Q_WR_LO;
      default: quarter = Q_WR_HI;
    endcase
  end

  assign lookup_o = bmp_en_i && (in_low || in_high);
  assign addr_o   = {quarter, idx_i[WIN_BITS-1:SEL_W]};
  assign sel_o    = idx_i[SEL_W-1:0];

  logic unused_top;
  assign unused_top = ^TOP_W;
endmodule

// File: rtl/msr_bit_pick.sv
module msr_bit_pick #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned SEL_W = $clog2(BYTE_W)
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              bit_o
);
  // lsb-first numbering within a byte
  assign bit_o = byte_i[sel_i];
endmodule

// File: rtl/msr_exit_unit.sv
module msr_exit_unit
  import msr_exit_pkg::*;
#(
  parameter int unsigned P_IDX_W    = IDX_W,
  parameter int unsigned P_WIN_BITS = WIN_BITS,
  parameter int unsigned P_BYTE_W   = BYTE_W,
  localparam int unsigned SEL_W  = $clog2(P_BYTE_W),
  localparam int unsigned ADDR_W = 2 + P_WIN_BITS - SEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [P_IDX_W-1:0]  req_idx_i,
  input  logic                req_write_i,
  input  logic                req_bmp_en_i,
  output logic                rsp_valid_o,
  output logic                rsp_exit_o,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [P_BYTE_W-1:0] mem_rdata_i
);
  logic              fire;
  logic              need_lookup;
  logic [SEL_W-1:0]  sel_d, sel_q;
  logic              pend_lookup_q, pend_force_q;
  logic              picked;

  msr_win_decode #(
    .IDX_W    (P_IDX_W),
    .WIN_BITS (P_WIN_BITS),
    .BYTE_W   (P_BYTE_W),
    .HIGH_BASE(HIGH_BASE[P_IDX_W-1:0])
  ) u_decode (
    .idx_i   (req_idx_i),
    .write_i (req_write_i),
    .bmp_en_i(req_bmp_en_i),
    .lookup_o(need_lookup),
    .addr_o  (mem_addr_o),
    .sel_o   (sel_d)
  );

  msr_bit_pick #(.BYTE_W(P_BYTE_W)) u_pick (
    .byte_i(mem_rdata_i),
    .sel_i (sel_q),
    .bit_o (picked)
  );

  assign req_ready_o = !pend_lookup_q;
  assign fire        = req_valid_i && req_ready_o;
  assign mem_req_o   = fire && need_lookup;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_lookup_q <= 1'b0;
      pend_force_q  <= 1'b0;
      sel_q         <= '0;
    end else begin
      pend_lookup_q <= fire && need_lookup;
      pend_force_q  <= fire && !need_lookup;
      if (fire && need_lookup) sel_q <= sel_d;
    end
  end

  assign rsp_valid_o = pend_lookup_q || pend_force_q;
  assign rsp_exit_o  = pend_force_q || (pend_lookup_q && picked);
endmodule

// File: rtl/msr_exit_unit_chk.sv
module msr_exit_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] req_idx_i,
  input logic        req_write_i,
  input logic        req_bmp_en_i,
  input logic        rsp_valid_o,
  input logic        rsp_exit_o,
  input logic        mem_req_o,
  input logic [11:0] mem_addr_o,
  input logic [7:0]  mem_rdata_i
);
  logic fire, lo_win, hi_win;
  assign fire   = req_valid_i && req_ready_o;
  assign lo_win = (req_idx_i[31:13] == 19'h0);
  assign hi_win = (req_idx_i[31:13] == 19'h60000);

  // R1
  bmp_off_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !req_bmp_en_i |-> !mem_req_o);
  // R1
  bmp_off_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !req_bmp_en_i |=> rsp_valid_o && rsp_exit_o);
  // R2
  out_of_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !lo_win && !hi_win |-> !mem_req_o ##1 (rsp_valid_o && rsp_exit_o));
  // R3
  rd_low_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && req_bmp_en_i && lo_win && !req_write_i |->
      mem_req_o && mem_addr_o == {2'b00, req_idx_i[12:3]});
  // R4
  rd_high_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && req_bmp_en_i && hi_win && !req_write_i |->
      mem_req_o && mem_addr_o == {2'b01, req_idx_i[12:3]});
  // R5
  wr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && req_bmp_en_i && (lo_win || hi_win) && req_write_i |->
      mem_req_o && mem_addr_o == {1'b1, hi_win, req_idx_i[12:3]});
  // R6
  bit_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> rsp_exit_o == mem_rdata_i[$past(req_idx_i[2:0])]);
  // R7
  rsp_after_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o);
  // R7
  no_stray_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !rsp_valid_o);
  // R8
  busy_after_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !req_ready_o);
  // R8
  mem_only_on_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> fire);
endmodule

bind msr_exit_unit msr_exit_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_idx_i   (req_idx_i),
  .req_write_i (req_write_i),
  .req_bmp_en_i(req_bmp_en_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_exit_o  (rsp_exit_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/msr_exit_unit_bench.sv
module msr_exit_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_idx = '0;
  logic        req_write = 1'b0;
  logic        req_bmp_en = 1'b0;
  logic        rsp_valid, rsp_exit;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  bmp [4096];

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  msr_exit_unit u_msr_exit_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_idx_i   (req_idx),
    .req_write_i (req_write),
    .req_bmp_en_i(req_bmp_en),
    .rsp_valid_o (rsp_valid),
    .rsp_exit_o  (rsp_exit),
    .mem_req_o   (mem_req),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= bmp[mem_addr];

  function automatic logic [7:0] byte_val(int a);
    return 8'(((a * 37) + 11) ^ (a >> 4));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(logic [31:0] idx, logic wr, logic en, logic exp_exit,
                        logic exp_lk, int exp_addr, string tag);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 idle", rsp_valid, 0);
    req_idx = idx; req_write = wr; req_bmp_en = en; req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R8 ready", req_ready, 1);
    chk(mem_req == exp_lk, tag, mem_req, exp_lk);
    if (exp_lk) chk(int'(mem_addr) == exp_addr, tag, mem_addr, exp_addr);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R7 strobe", rsp_valid, 1);
    chk(rsp_exit == exp_exit, exp_lk ? "R6 verdict" : tag, rsp_exit, exp_exit);
    if (exp_lk) chk(req_ready == 1'b0, "R8 busy", req_ready, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 4096; a++) bmp[a] = byte_val(a);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R9 valid", rsp_valid, 0);
    chk(mem_req == 1'b0, "R9 mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 valid after release", rsp_valid, 0);

    // R3 R4 R5 R6: every index of every quarter
    for (int q = 0; q < 4; q++) begin
      for (int n = 0; n < 8192; n++) begin
        logic [31:0] idx;
        int a;
        logic [7:0] b;
        idx = (q[0] ? 32'hC000_0000 : 32'h0) | 32'(n);
        a = q * 1024 + (n >> 3);
        b = byte_val(a);
        do_req(idx, q[1], 1'b1, b[n & 7], 1'b1, a,
               q[1] ? "R5 addr" : (q[0] ? "R4 addr" : "R3 addr"));
      end
    end

    // R2 out-of-window indices, both directions
    begin
      logic [31:0] outs [6];
      outs = '{32'h0000_2000, 32'hBFFF_FFFF, 32'hC000_2000,
               32'hFFFF_FFFF, 32'h8000_0000, 32'h0001_0000};
      foreach (outs[k]) begin
        do_req(outs[k], 1'b0, 1'b1, 1'b1, 1'b0, 0, "R2 out of window");
        do_req(outs[k], 1'b1, 1'b1, 1'b1, 1'b0, 0, "R2 out of window");
      end
    end

    // R1 enable clear: exits even where bitmap bit is 0
    for (int n = 0; n < 64; n++) begin
      do_req(32'(n), 1'b0, 1'b0, 1'b1, 1'b0, 0, "R1 bitmaps off");
      do_req(32'hC000_0000 | 32'(n), 1'b1, 1'b0, 1'b1, 1'b0, 0, "R1 bitmaps off");
    end

    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 final idle", rsp_valid, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule